// File: doc/BRIEF.md
# Register-Driven Three-Wire Serial EEPROM Master

This block runs a 512 x 8 serial EEPROM over a three-wire link: a chip select, a serial clock and a data line in each direction. Software never toggles a pin. It fills in a control word with an operation code and a byte address. For a store it also places the byte in a data word. It then sets a start bit. From that point the block builds the whole serial frame and keeps to the device's timing. After a store it waits for the device to report that programming is done. After a fetch it captures the returned byte. At the end it drops the start bit and the busy flag together.

Software sees four 32-bit words, selected by a 2-bit index. Writes and reads use separate indices, so a status poll and a register write can be issued in the same cycle. The block supports three commands: fetch, store, and the write-unlock command that must be sent once before the first store. The serial clock is a fixed division of the system clock. The default gives at most 1 MHz from 250 MHz. A store whose completion never shows up is ended by a cycle-count timeout, which sets an error bit.

Top module: `nvm_serial_master`

## Requirements
- R1: After reset all four register words read 0, and chip select, serial clock and serial data-out to the device are low.
- R2: Index 0 (command) holds the start bit at bit 31. Index 1 (control) holds the opcode in bits 17:16 and the 9-bit address in bits 8:0. Index 2 (status) holds busy at bit 31 and the timeout error at bit 0. Index 3 (data) holds a byte in bits 7:0. Every other bit reads 0.
- R3: A write to index 0 with bit 31 set, while not busy, makes start and busy read 1 from the next cycle on.
- R4: Each frame raises chip select and then sends, MSB first, a 1, the two opcode bits and the nine address bits. Opcode 10 is a fetch and 01 is a store. Opcode 00 with address bits 8:7 = 11 is the write-unlock. The device samples the data line on the rising serial-clock edge, and the line does not change while the serial clock is high.
- R5: A fetch discards the leading dummy bit and captures the next 8 bits, MSB first, into the data word when the command ends.
- R6: A store sends the 8 data bits MSB first. It then holds chip select low for at least one full serial-clock period, raises it again, and finishes only when the device's data line is high.
- R7: When a command ends, start and busy both return to 0 in the same cycle.
- R8: Register writes that arrive while busy is 1 have no effect.
- R9: If the device data line stays low for TMO_CYC cycles of completion polling, the command ends and the error bit is set. A later accepted start clears the error bit.
- R10: Each high phase of the serial clock lasts exactly HALF_DIV system cycles.
- R11: The serial clock is never high while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register index for writes |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 2 | Register index for reads |
| reg_rdata | output | 32 | Register read data (combinational) |
| ee_cs | output | 1 | Device chip select, active high |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data / ready from the device |

## Verification
Two things can happen in the same cycle: the end of a command, which clears busy, and a host write to the control word. The bench provokes this by issuing a control write on every cycle during a fetch. Each write carries a different address, and in each cycle the bench also reads the status word. The control word must end up holding the value from the first write issued in a cycle where status showed busy clear. Every earlier write, including one that lands in the completion cycle itself, must be dropped.

// File: rtl/nvmw_pkg.sv
package nvmw_pkg;
  typedef enum logic [1:0] {
    OP_CTL = 2'b00,
    OP_WR  = 2'b01,
    OP_RD  = 2'b10,
    OP_ER  = 2'b11
  } mw_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEND,
    S_RECV,
    S_GAP,
    S_POLL,
    S_FIN
  } seq_st_e;

  localparam logic [1:0] IDX_CMD = 2'd0;
  localparam logic [1:0] IDX_CTL = 2'd1;
  localparam logic [1:0] IDX_STA = 2'd2;
  localparam logic [1:0] IDX_DAT = 2'd3;
  localparam int OPC_LSB = 16;
endpackage

// File: rtl/nvmw_tick.sv
module nvmw_tick #(
  parameter int HALF_DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic at_end;

  assign at_end = (cnt_q == CW'(HALF_DIV - 1));
  assign tick   = run && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (HALF_DIV > 1) begin : g_chk
      // R10: half-period strobes are never back to back
      a_r10_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/nvmw_regs.sv
module nvmw_regs
  import nvmw_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        waddr,
  input  logic [31:0]       wdata,
  input  logic [1:0]        raddr,
  output logic [31:0]       rdata,
  input  logic              done,
  input  logic              done_err,
  input  logic              done_rd,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              start,
  output mw_op_e            op,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] txbyte
);
  logic              start_q, start_d;
  logic              err_q, err_d;
  mw_op_e            op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              accept, go;

  assign accept = we && !start_q;
  assign go     = accept && (waddr == IDX_CMD) && wdata[31];

  always_comb begin
    op_d    = op_q;
    addr_d  = addr_q;
    dat_d   = dat_q;
    start_d = start_q;
    err_d   = err_q;
    if (accept && waddr == IDX_CTL) begin
      op_d   = mw_op_e'(wdata[OPC_LSB+1:OPC_LSB]);
      addr_d = wdata[ADDR_W-1:0];
    end
    if (accept && waddr == IDX_DAT) dat_d = wdata[DATA_W-1:0];
    else if (done && done_rd)       dat_d = rx_byte;
    if (done) begin
      start_d = 1'b0;
      err_d   = done_err;
    end else if (go) begin
      start_d = 1'b1;
      err_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_CTL;
      addr_q  <= '0;
      dat_q   <= '0;
      start_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      op_q    <= op_d;
      addr_q  <= addr_d;
      dat_q   <= dat_d;
      start_q <= start_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    case (raddr)
      IDX_CMD: rdata = {start_q, 31'b0};
      IDX_CTL: rdata = (32'(op_q) << OPC_LSB) | 32'(addr_q);
      IDX_STA: rdata = {start_q, 30'b0, err_q};
      default: rdata = 32'(dat_q);
    endcase
  end

  assign start  = start_q;
  assign op     = op_q;
  assign addr   = addr_q;
  assign txbyte = dat_q;

  // R3: an accepted start shows busy in the next cycle
  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> start_q);
  // R7: completion drops start and busy
  a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !start_q);
  // R8: control fields frozen against writes while busy
  a_r8_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (we && start_q) |=> ($stable(addr_q) && $stable(op_q)));
  // R9: a new start clears the error flag
  a_r9_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !err_q);
endmodule

// File: rtl/nvmw_seq.sv
module nvmw_seq
  import nvmw_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 8,
  parameter int TMO_CYC = 2_500_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mw_op_e            op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] txbyte,
  input  logic              tick,
  input  logic              mw_do,
  output logic              run,
  output logic              mw_cs,
  output logic              mw_sk,
  output logic              mw_di,
  output logic              done,
  output logic              done_err,
  output logic              done_rd,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int HDR_W = 3 + ADDR_W;
  localparam int FRM_W = HDR_W + DATA_W;
  localparam int BCW   = $clog2(FRM_W + 1);
  localparam int TW    = $clog2(TMO_CYC + 1);

  seq_st_e           st_q, st_d;
  logic [FRM_W-1:0]  sh_q, sh_d;
  logic [BCW-1:0]    bc_q, bc_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [TW-1:0]     tm_q, tm_d;
  logic              sk_q, sk_d, cs_q, cs_d, te_q, te_d;
  logic              last;

  assign last = (bc_q == BCW'(1));

  always_comb begin
    st_d = st_q; sh_d = sh_q; bc_d = bc_q; rx_d = rx_q;
    tm_d = tm_q; sk_d = sk_q; cs_d = cs_q; te_d = te_q;
    case (st_q)
      S_IDLE: if (start) begin
        sh_d = {1'b1, op, addr, txbyte};
        bc_d = (op == OP_WR) ? BCW'(FRM_W) : BCW'(HDR_W);
        cs_d = 1'b1;
        te_d = 1'b0;
        st_d = S_SEND;
      end
      S_SEND, S_RECV: if (tick) begin
        if (!sk_q) sk_d = 1'b1;
        else begin
          sk_d = 1'b0;
          rx_d = {rx_q[DATA_W-2:0], mw_do};
          bc_d = bc_q - 1'b1;
          if (st_q == S_SEND) sh_d = {sh_q[FRM_W-2:0], 1'b0};
          if (last) begin
            if (st_q == S_SEND && op == OP_RD) begin
              bc_d = BCW'(DATA_W);
              st_d = S_RECV;
            end else if (st_q == S_SEND && op == OP_WR) begin
              bc_d = BCW'(2);
              cs_d = 1'b0;
              st_d = S_GAP;
            end else begin
              cs_d = 1'b0;
              st_d = S_FIN;
            end
          end
        end
      end
      S_GAP: if (tick) begin
        bc_d = bc_q - 1'b1;
        if (last) begin
          cs_d = 1'b1;
          tm_d = '0;
          st_d = S_POLL;
        end
      end
      S_POLL: begin
        if (mw_do) begin
          cs_d = 1'b0;
          st_d = S_FIN;
        end else if (tm_q == TW'(TMO_CYC - 1)) begin
          te_d = 1'b1;
          cs_d = 1'b0;
          st_d = S_FIN;
        end else tm_d = tm_q + 1'b1;
      end
      S_FIN: if (tick) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; sh_q <= '0; bc_q <= '0; rx_q <= '0;
      tm_q <= '0; sk_q <= 1'b0; cs_q <= 1'b0; te_q <= 1'b0;
    end else begin
      st_q <= st_d; sh_q <= sh_d; bc_q <= bc_d; rx_q <= rx_d;
      tm_q <= tm_d; sk_q <= sk_d; cs_q <= cs_d; te_q <= te_d;
    end
  end

  assign run      = (st_q != S_IDLE);
  assign mw_cs    = cs_q;
  assign mw_sk    = sk_q;
  assign mw_di    = (st_q == S_SEND) && sh_q[FRM_W-1];
  assign done     = (st_q == S_FIN) && tick;
  assign done_err = te_q;
  assign done_rd  = (op == OP_RD);
  assign rx_byte  = rx_q;

  // R11: serial clock only pulses inside a selected frame
  a_r11_sk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    mw_sk |-> mw_cs);
  // R4: data line holds while the serial clock is high
  a_r4_di_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_sk && $past(mw_sk)) |-> $stable(mw_di));
  // R9: only a store can end in a timeout
  a_r9_tmo_store_only: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err) |-> (op == OP_WR));
  // R6: completion polling happens with chip select raised
  a_r6_poll_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_POLL) |-> mw_cs);
endmodule

// File: rtl/nvm_serial_master.sv
module nvm_serial_master
  import nvmw_pkg::*;
#(
  parameter int HALF_DIV = 125,
  parameter int TMO_CYC  = 2_500_000,
  parameter int ADDR_W   = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_waddr,
  input  logic [31:0] reg_wdata,
  input  logic [1:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do
);
  localparam int DATA_W = 8;

  logic [1:0]        rs_q;
  logic              rst_i_n;
  logic              start, done, done_err, done_rd, run, tick;
  mw_op_e            op;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] txbyte, rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  nvmw_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .we(reg_we), .waddr(reg_waddr),
    .wdata(reg_wdata), .raddr(reg_raddr), .rdata(reg_rdata),
    .done(done), .done_err(done_err), .done_rd(done_rd), .rx_byte(rx_byte),
    .start(start), .op(op), .addr(addr), .txbyte(txbyte)
  );

  nvmw_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_i_n), .run(run), .tick(tick)
  );

  nvmw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_CYC(TMO_CYC)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .start(start), .op(op), .addr(addr),
    .txbyte(txbyte), .tick(tick), .mw_do(ee_do), .run(run),
    .mw_cs(ee_cs), .mw_sk(ee_sk), .mw_di(ee_di), .done(done),
    .done_err(done_err), .done_rd(done_rd), .rx_byte(rx_byte)
  );
endmodule

// File: tb/tb_nvm_serial_master.sv
module tb_nvm_serial_master;
  localparam int HALF = 3;
  localparam int TMO  = 600;
  localparam int PROG = 150;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_we;
  logic [1:0] reg_waddr, reg_raddr;
  logic [31:0] reg_wdata, reg_rdata;
  logic ee_cs, ee_sk, ee_di, ee_do;

  int n_vec = 0, n_bad = 0, wdog = 0;
  bit finished = 0;

  // device model state
  logic [7:0] mem [512];
  logic [7:0] exp_mem [512];
  logic sk_p = 0, cs_p = 0, rd_mode = 0, rd_bit = 0, ewen_m = 0, have_wr = 0;
  logic prog_busy = 0, stuck = 0, armed_gap = 0;
  logic [19:0] fr = '0;
  logic [11:0] last_hdr = '0;
  logic [8:0] rd_a = '0, wa = '0;
  logic [7:0] wd = '0;
  int bitn = 0, rd_i = 0, prog_cnt = 0, sk_hi = 0, sk_bad = 0, idle_bad = 0;
  int cs_lo = 0, gap_min = 1000;

  assign ee_do = rd_mode ? rd_bit : (ee_cs && !prog_busy);

  nvm_serial_master #(.HALF_DIV(HALF), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic logic [31:0] ctl_word(input logic [1:0] op, input logic [8:0] a);
    return (32'(op) << 16) | 32'(a);
  endfunction

  function automatic logic [11:0] hdr(input logic [1:0] op, input logic [8:0] a);
    return {1'b1, op, a};
  endfunction

  always @(posedge clk) begin
    if (ee_sk && !sk_p && ee_cs) begin
      if (rd_mode) begin
        if (rd_i < 8) rd_bit = mem[rd_a][7 - rd_i];
        rd_i++;
      end else if (bitn > 0 || ee_di) begin
        fr = {fr[18:0], ee_di};
        bitn++;
        if (bitn == 12) begin
          last_hdr = fr[11:0];
          if (fr[10:9] == 2'b10) begin
            rd_mode = 1; rd_a = fr[8:0]; rd_i = 0; rd_bit = 0;
          end else if (fr[10:9] == 2'b00 && fr[8:7] == 2'b11) ewen_m = 1;
        end
        if (bitn == 20 && fr[18:17] == 2'b01) begin
          have_wr = 1; wa = fr[16:8]; wd = fr[7:0];
        end
      end
    end
    if (ee_sk) sk_hi++;
    else if (sk_p) begin
      if (sk_hi != HALF) sk_bad++;
      sk_hi = 0;
    end
    if (ee_sk && !ee_cs) idle_bad++;
    if (cs_p && !ee_cs) begin
      bitn = 0; rd_mode = 0;
      if (have_wr) begin
        have_wr = 0; cs_lo = 0; armed_gap = 1;
        if (ewen_m) begin prog_busy = 1; prog_cnt = PROG; end
      end
    end
    if (armed_gap) begin
      if (!ee_cs) cs_lo++;
      else begin
        armed_gap = 0;
        if (cs_lo < gap_min) gap_min = cs_lo;
      end
    end
    if (prog_busy && !stuck) begin
      prog_cnt--;
      if (prog_cnt == 0) begin mem[wa] = wd; prog_busy = 0; end
    end
    cs_p = ee_cs; sk_p = ee_sk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    reg_raddr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    int n = 0;
    reg_rd(2'd2, s);
    while (s[31] && n < 5000) begin
      @(negedge clk);
      reg_rd(2'd2, s);
      n++;
    end
    chk(tag, 32'(s[31]), 32'd0);
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [8:0] a, input logic [7:0] d);
    reg_wr(2'd1, ctl_word(op, a));
    reg_wr(2'd3, 32'(d));
    reg_wr(2'd0, 32'h8000_0000);
    wait_idle("R7 busy cleared");
  endtask

  initial begin : main
    logic [31:0] v;
    for (int i = 0; i < 512; i++) begin
      mem[i] = init_val(i); exp_mem[i] = init_val(i);
    end
    void'($urandom(32'd1234));
    rst_n = 0; reg_we = 0; reg_waddr = 0; reg_wdata = 0; reg_raddr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int k = 0; k < 4; k++) begin
      reg_rd(2'(k), v);
      chk("R1 reset reg", v, 32'd0);
    end
    chk("R1 reset pins", {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);

    // R2 field layout and reserved bits
    reg_wr(2'd1, 32'hFFFF_FFFF); reg_rd(2'd1, v); chk("R2 ctl mask", v, 32'h0003_01FF);
    reg_wr(2'd3, 32'hABCD_EF12); reg_rd(2'd3, v); chk("R2 dat mask", v, 32'h0000_0012);
    reg_wr(2'd0, 32'h7FFF_FFFF); reg_rd(2'd0, v); chk("R2 cmd reserved", v, 32'd0);
    reg_rd(2'd2, v); chk("R2 sta idle", v, 32'd0);

    // R3 start -> busy next cycle; write-unlock frame R4
    reg_wr(2'd1, ctl_word(2'b00, 9'h180));
    reg_wr(2'd0, 32'h8000_0000);
    reg_rd(2'd2, v); chk("R3 busy set", v, 32'h8000_0000);
    reg_rd(2'd0, v); chk("R3 start set", v, 32'h8000_0000);
    // R8 writes ignored while busy
    reg_wr(2'd1, ctl_word(2'b10, 9'h055));
    reg_rd(2'd1, v); chk("R8 ctl unchanged", v, ctl_word(2'b00, 9'h180));
    wait_idle("R7 busy cleared");
    reg_rd(2'd0, v); chk("R7 start cleared", v, 32'd0);
    chk("R4 unlock frame", 32'(last_hdr), 32'(hdr(2'b00, 9'h180)));
    chk("R4 unlock seen", 32'(ewen_m), 32'd1);

    // directed stores / fetches at boundary addresses and values
    run_cmd(2'b01, 9'h1FF, 8'hFF); exp_mem[511] = 8'hFF;
    run_cmd(2'b01, 9'h000, 8'h00); exp_mem[0] = 8'h00;
    run_cmd(2'b01, 9'h0AA, 8'hA5); exp_mem[170] = 8'hA5;
    chk("R6 stored 1FF", 32'(mem[511]), 32'hFF);
    chk("R6 stored 000", 32'(mem[0]), 32'h00);
    chk("R6 gap length", 32'(gap_min >= 2 * HALF), 32'd1);
    run_cmd(2'b10, 9'h1FF, 8'h00); reg_rd(2'd3, v); chk("R5 fetch 1FF", v, 32'hFF);
    chk("R4 fetch frame", 32'(last_hdr), 32'(hdr(2'b10, 9'h1FF)));
    run_cmd(2'b10, 9'h0AA, 8'h00); reg_rd(2'd3, v); chk("R5 fetch 0AA", v, 32'hA5);
    run_cmd(2'b10, 9'h003, 8'h00); reg_rd(2'd3, v); chk("R5 fetch init", v, 32'(init_val(3)));

    // random mix
    for (int i = 0; i < 24; i++) begin
      logic [8:0] a = 9'($urandom % 512);
      logic [7:0] d = 8'($urandom);
      if ($urandom % 2) begin
        run_cmd(2'b01, a, d); exp_mem[a] = d;
        reg_rd(2'd2, v); chk("R9 no error on store", v, 32'd0);
        chk("R6 random store", 32'(mem[a]), 32'(d));
      end else begin
        run_cmd(2'b10, a, 8'h00);
        reg_rd(2'd3, v); chk("R5 random fetch", v, 32'(exp_mem[a]));
      end
    end

    // R9 timeout
    stuck = 1;
    run_cmd(2'b01, 9'h044, 8'h3C);
    reg_rd(2'd2, v); chk("R9 error set", v, 32'h0000_0001);
    stuck = 0;
    repeat (PROG + 5) @(negedge clk);
    exp_mem[68] = 8'h3C;
    reg_wr(2'd1, ctl_word(2'b10, 9'h044));
    reg_wr(2'd0, 32'h8000_0000);
    reg_rd(2'd2, v); chk("R9 error cleared by start", v, 32'h8000_0000);
    wait_idle("R7 busy cleared");
    reg_rd(2'd3, v); chk("R5 fetch after timeout", v, 32'h3C);

    // overlap: control writes hammered while a fetch completes
    begin
      logic [8:0] k = 9'd1;
      logic [8:0] exp_a = 9'd0;
      bit got = 0;
      reg_wr(2'd1, ctl_word(2'b10, 9'h000));
      reg_wr(2'd0, 32'h8000_0000);
      for (int n = 0; n < 4000 && !got; n++) begin
        @(negedge clk);
        reg_raddr = 2'd2; reg_we = 1; reg_waddr = 2'd1;
        reg_wdata = ctl_word(2'b10, k);
        #1;
        if (!reg_rdata[31]) begin got = 1; exp_a = k; end
        k = k + 9'd1;
      end
      @(negedge clk); reg_we = 0;
      reg_rd(2'd1, v); chk("R8 overlap first free write", v, ctl_word(2'b10, exp_a));
    end

    // R10 / R11 monitors
    chk("R10 sk high width", 32'(sk_bad), 32'd0);
    chk("R11 sk without cs", 32'(idle_bad), 32'd0);
    chk("R11 idle pins", {30'd0, ee_cs, ee_sk}, 32'd0);

    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    wdog++;
    if (wdog > 190000 && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule